// File: doc/BRIEF.md
# Marker-Chain Fall-Through FIFO

This block is an elastic queue of sixteen 4-bit words. It is built as a linear chain of word stages rather than a RAM with pointers. Each stage holds one data word and one occupancy marker. On every clock, a filled stage moves its word into an empty neighbour on the output side. Stored words therefore gather at the output end, and vacancies drift back to the input end, one position per clock.

A writer loads words with a shift-in strobe and a reader removes them with a shift-out strobe. Both strobes are level signals from outside the clock domain, and each is passed through a two-flop synchroniser before its edges are used. The writer watches an input-ready flag, which is the inverse of the first stage's marker. The reader watches an output-ready flag, which is the last stage's marker gated by the drain controller.

Two small state machines handle the strobe handshakes. The fill controller has the states FILL_IDLE, FILL_HOLD and FILL_WAIT:
- IDLE goes to HOLD on a shift-in rise when the first stage is vacant, and loads the word.
- IDLE goes to WAIT on a shift-in rise when the first stage is occupied.
- WAIT goes to HOLD, loading the word, when a vacancy reaches the first stage while shift-in is still high.
- WAIT goes back to IDLE if shift-in drops first.
- HOLD goes to IDLE when shift-in drops, which releases the word into the chain.

The drain controller has the states DRAIN_IDLE, DRAIN_BUSY, DRAIN_ARMED and DRAIN_SPENT:
- IDLE goes to BUSY on a shift-out rise when a word is present.
- IDLE goes to ARMED on a shift-out rise when the FIFO is empty.
- BUSY goes to IDLE when shift-out drops, and consumes the word.
- ARMED goes to SPENT when a word arrives while shift-out is held; that word is consumed automatically.
- ARMED and SPENT both go to IDLE when shift-out drops.

Top module: `ripple_fifo`

## Requirements
- R1: While `mr` is high, all markers are cleared asynchronously. Once `mr` is low again, `in_ready` reads 1 and `out_ready` reads 0, and the word on `dout` keeps the value it had before reset.
- R2: If `shift_in` is already high while `mr` is asserted, the word on `din` is loaded once reset is released: `in_ready` goes low and the word later reaches the output.
- R3: A synchronised rising edge of `shift_in` with the first stage vacant loads `din` and drives `in_ready` low. The word stays in the first stage, with `out_ready` low, for as long as `shift_in` stays high.
- R4: Once released, a word advances one stage per clock. With the FIFO empty, `out_ready` is still 0 after the 16th rising clock edge following the fall of `shift_in`, and is 1 after the 17th.
- R5: Words leave in the order they were accepted. While `out_ready` is 1, `dout` shows the oldest stored word.
- R6: Once sixteen words have settled, `in_ready` stays 0. A `shift_in` pulse that starts and ends while the FIFO is full adds nothing.
- R7: If `shift_in` is held high while the FIFO is full, the word on `din` is loaded when a vacancy reaches the first stage.
- R8: While `shift_out` is high, `out_ready` is 0. On its fall the shown word is removed, and `out_ready` returns to 1 only when another word reaches the last stage.
- R9: When the FIFO runs empty, `dout` keeps the last word shifted out.
- R10: If `shift_out` is held high while the FIFO is empty, an arriving word raises `out_ready` for exactly one clock and is removed. A further word is not offered (`out_ready` stays 0) until `shift_out` has gone low.
- R11: `dout_valid` equals the inverse of `oe_n`, and `dout` reads all zeros while `oe_n` is 1.
- R12: Strobes applied without looking at the flags, with at least two clocks high and two low, are accepted in order as long as the FIFO is not full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock that moves the markers |
| mr | input | 1 | Asynchronous master reset, active high |
| shift_in | input | 1 | Write strobe; its rising edge loads `din` |
| shift_out | input | 1 | Read strobe; its falling edge removes the shown word |
| din | input | 4 | Word to load |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 4 | Word in the last stage, zero while disabled |
| dout_valid | output | 1 | High when `dout` is driven (stands in for tri-state) |
| in_ready | output | 1 | First stage vacant |
| out_ready | output | 1 | Last stage holds a word that may be read |

## Verification
The hardest situations to reach are the two held-strobe cases. One is a shift-in held high on a full FIFO that must wait for a vacancy to bubble up through all sixteen stages. The other is a shift-out held high on an empty FIFO that must catch a one-clock `out_ready` pulse and then refuse the next word. The bench reaches them directly by filling the queue to capacity, raising and holding the opposing strobe, and only then performing the single read or write that starts the bubble. Burst pulses on a full queue, and a reset with `shift_in` high, are applied in the same directed way. Constrained random handshakes are then mixed in to cover occupancy levels between empty and full against a reference queue.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;

    // Fill-side handshake states
    typedef enum logic [1:0] {
        FILL_IDLE,
        FILL_HOLD,
        FILL_WAIT
    } fill_state_e;

    // Drain-side handshake states
    typedef enum logic [1:0] {
        DRAIN_IDLE,
        DRAIN_BUSY,
        DRAIN_ARMED,
        DRAIN_SPENT
    } drain_state_e;

endpackage

// File: rtl/rf_strobe_sync.sv
module rf_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic mr,
    input  logic strobe_raw,
    output logic strobe_level,
    output logic strobe_rise
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] pipe_q;
    logic          prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or posedge mr) begin
                if (mr) pipe_q <= '0;
                else    pipe_q <= strobe_raw;
            end
        end else begin : g_multi
            always_ff @(posedge clk or posedge mr) begin
                if (mr) pipe_q <= '0;
                else    pipe_q <= {pipe_q[LAST-1:0], strobe_raw};
            end
        end
    endgenerate

    // Previous synchronised level, used to turn the level into an edge event
    always_ff @(posedge clk or posedge mr) begin
        if (mr) prev_q <= 1'b0;
        else    prev_q <= pipe_q[LAST];
    end

    assign strobe_level = pipe_q[LAST];
    assign strobe_rise  = pipe_q[LAST] & ~prev_q;

endmodule

// File: rtl/rf_word_chain.sv
module rf_word_chain #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             mr,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    input  logic             hold_first,
    input  logic             consume,
    output logic [DEPTH-1:0] mark_q,
    output logic [WIDTH-1:0] last_word,
    output logic             hop_last
);
    localparam int TOP = DEPTH - 1;

    logic [DEPTH-1:0]            enter;
    logic [DEPTH-1:0]            leave;
    logic [DEPTH-1:0]            mark_d;
    logic [DEPTH-1:0][WIDTH-1:0] word_d;
    logic [DEPTH-1:0][WIDTH-1:0] word_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            // A word enters stage i from the strobe (i == 0) or from stage i-1
            if (i == 0) begin : g_head
                assign enter[i]  = load;
                assign word_d[i] = load ? load_word : word_q[i];
            end else if (i == 1) begin : g_second
                assign enter[i]  = mark_q[i-1] & ~mark_q[i] & ~hold_first;
                assign word_d[i] = enter[i] ? word_q[i-1] : word_q[i];
            end else begin : g_body
                assign enter[i]  = mark_q[i-1] & ~mark_q[i];
                assign word_d[i] = enter[i] ? word_q[i-1] : word_q[i];
            end

            // A word leaves stage i toward the output or to the reader
            if (i == TOP) begin : g_tail
                assign leave[i] = consume;
            end else begin : g_pass
                assign leave[i] = enter[i+1];
            end

            assign mark_d[i] = (mark_q[i] & ~leave[i]) | enter[i];
        end
    endgenerate

    always_ff @(posedge clk or posedge mr) begin
        if (mr) mark_q <= '0;
        else    mark_q <= mark_d;
    end

    // Data latches have no reset: contents survive a master reset
    always_ff @(posedge clk) begin
        word_q <= word_d;
    end

    assign last_word = word_q[TOP];
    assign hop_last  = enter[TOP];

endmodule

// File: rtl/rf_fill_ctrl.sv
module rf_fill_ctrl
    import ripple_fifo_pkg::*;
(
    input  logic clk,
    input  logic mr,
    input  logic strobe_rise,
    input  logic strobe_level,
    input  logic first_full,
    output logic load,
    output logic hold_first
);
    fill_state_e state_q;
    fill_state_e state_d;

    always_ff @(posedge clk or posedge mr) begin
        if (mr) state_q <= FILL_IDLE;
        else    state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_IDLE: begin
                if (strobe_rise) state_d = first_full ? FILL_WAIT : FILL_HOLD;
            end
            FILL_WAIT: begin
                if (!strobe_level)   state_d = FILL_IDLE;
                else if (!first_full) state_d = FILL_HOLD;
            end
            FILL_HOLD: begin
                if (!strobe_level) state_d = FILL_IDLE;
            end
            default: state_d = FILL_IDLE;
        endcase
    end

    always_comb begin
        load       = 1'b0;
        hold_first = 1'b0;
        unique case (state_q)
            FILL_IDLE: load       = strobe_rise & ~first_full;
            FILL_WAIT: load       = strobe_level & ~first_full;
            FILL_HOLD: hold_first = strobe_level;
            default: begin
                load       = 1'b0;
                hold_first = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rf_drain_ctrl.sv
module rf_drain_ctrl
    import ripple_fifo_pkg::*;
(
    input  logic clk,
    input  logic mr,
    input  logic strobe_rise,
    input  logic strobe_level,
    input  logic last_full,
    output logic consume,
    output logic show
);
    drain_state_e state_q;
    drain_state_e state_d;

    always_ff @(posedge clk or posedge mr) begin
        if (mr) state_q <= DRAIN_IDLE;
        else    state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DRAIN_IDLE: begin
                if (strobe_rise) state_d = last_full ? DRAIN_BUSY : DRAIN_ARMED;
            end
            DRAIN_BUSY: begin
                if (!strobe_level) state_d = DRAIN_IDLE;
            end
            DRAIN_ARMED: begin
                if (!strobe_level)  state_d = DRAIN_IDLE;
                else if (last_full) state_d = DRAIN_SPENT;
            end
            DRAIN_SPENT: begin
                if (!strobe_level) state_d = DRAIN_IDLE;
            end
            default: state_d = DRAIN_IDLE;
        endcase
    end

    always_comb begin
        consume = 1'b0;
        show    = 1'b0;
        unique case (state_q)
            DRAIN_IDLE:  show = 1'b1;
            DRAIN_BUSY:  consume = ~strobe_level;
            DRAIN_ARMED: begin
                show    = 1'b1;
                consume = strobe_level & last_full;
            end
            DRAIN_SPENT: show = 1'b0;
            default: begin
                consume = 1'b0;
                show    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo #(
    parameter int DEPTH       = 16,
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             mr,
    input  logic             shift_in,
    input  logic             shift_out,
    input  logic [WIDTH-1:0] din,
    input  logic             oe_n,
    output logic [WIDTH-1:0] dout,
    output logic             dout_valid,
    output logic             in_ready,
    output logic             out_ready
);
    localparam int TOP = DEPTH - 1;

    logic             si_level;
    logic             si_rise;
    logic             so_level;
    logic             so_rise;
    logic             fill_load;
    logic             fill_hold;
    logic             drain_consume;
    logic             drain_show;
    logic [DEPTH-1:0] mark_q;
    logic [WIDTH-1:0] last_word;
    logic             hop_last;

    rf_strobe_sync #(.STAGES(SYNC_STAGES)) u_si_sync (
        .clk          (clk),
        .mr           (mr),
        .strobe_raw   (shift_in),
        .strobe_level (si_level),
        .strobe_rise  (si_rise)
    );

    rf_strobe_sync #(.STAGES(SYNC_STAGES)) u_so_sync (
        .clk          (clk),
        .mr           (mr),
        .strobe_raw   (shift_out),
        .strobe_level (so_level),
        .strobe_rise  (so_rise)
    );

    rf_fill_ctrl u_fill (
        .clk          (clk),
        .mr           (mr),
        .strobe_rise  (si_rise),
        .strobe_level (si_level),
        .first_full   (mark_q[0]),
        .load         (fill_load),
        .hold_first   (fill_hold)
    );

    rf_drain_ctrl u_drain (
        .clk          (clk),
        .mr           (mr),
        .strobe_rise  (so_rise),
        .strobe_level (so_level),
        .last_full    (mark_q[TOP]),
        .consume      (drain_consume),
        .show         (drain_show)
    );

    rf_word_chain #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chain (
        .clk        (clk),
        .mr         (mr),
        .load       (fill_load),
        .load_word  (din),
        .hold_first (fill_hold),
        .consume    (drain_consume),
        .mark_q     (mark_q),
        .last_word  (last_word),
        .hop_last   (hop_last)
    );

    assign in_ready   = ~mark_q[0];
    assign out_ready  = mark_q[TOP] & drain_show;
    assign dout_valid = ~oe_n;
    assign dout       = oe_n ? '0 : last_word;

endmodule

// File: rtl/ripple_fifo_chk.sv
module ripple_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             mr,
    input logic [DEPTH-1:0] mark,
    input logic             load,
    input logic             hold_first,
    input logic             consume,
    input logic             hop_last,
    input logic [WIDTH-1:0] last_data,
    input logic             in_ready,
    input logic             out_ready
);

    // R1
    reset_flags_chk: assert property (@(posedge clk) disable iff (mr)
        $past(mr) |-> (in_ready && !out_ready));

    // R3
    load_busy_chk: assert property (@(posedge clk) disable iff (mr)
        load |=> !in_ready);

    // R3
    hold_first_chk: assert property (@(posedge clk) disable iff (mr)
        hold_first |=> mark[0]);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (mr)
        ($countones(mark) + int'($past(consume)))
            == ($past($countones(mark)) + int'($past(load))));

    // R8
    consume_clears_chk: assert property (@(posedge clk) disable iff (mr)
        consume |=> !out_ready);

    // R9
    last_word_keep_chk: assert property (@(posedge clk) disable iff (mr)
        !hop_last |=> $stable(last_data));

endmodule

bind ripple_fifo ripple_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) chk_i (
    .clk        (clk),
    .mr         (mr),
    .mark       (mark_q),
    .load       (fill_load),
    .hold_first (fill_hold),
    .consume    (drain_consume),
    .hop_last   (hop_last),
    .last_data  (last_word),
    .in_ready   (in_ready),
    .out_ready  (out_ready)
);

// File: tb/ripple_fifo_tb_top.sv
module ripple_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int WIDTH      = 4;

    logic             clk       = 1'b0;
    logic             mr        = 1'b0;
    logic             shift_in  = 1'b0;
    logic             shift_out = 1'b0;
    logic             oe_n      = 1'b0;
    logic [WIDTH-1:0] din       = '0;
    logic [WIDTH-1:0] dout;
    logic             dout_valid;
    logic             in_ready;
    logic             out_ready;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [WIDTH-1:0] model_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ripple_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
        .clk        (clk),
        .mr         (mr),
        .shift_in   (shift_in),
        .shift_out  (shift_out),
        .din        (din),
        .oe_n       (oe_n),
        .dout       (dout),
        .dout_valid (dout_valid),
        .in_ready   (in_ready),
        .out_ready  (out_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        mr = 1'b1;
        tick(3);
        mr = 1'b0;
        tick(1);
    endtask

    // Flag-respecting write; extra = additional clocks shift_in stays high
    task automatic push_hs(input logic [WIDTH-1:0] w, input int extra);
        while (!in_ready) @(negedge clk);
        din      = w;
        shift_in = 1'b1;
        @(negedge clk);
        while (in_ready) @(negedge clk);
        tick(extra);
        shift_in = 1'b0;
        model_q.push_back(w);
        tick(1);
    endtask

    // Flag-respecting read with order check
    task automatic pop_hs();
        while (!out_ready) @(negedge clk);
        chk(dout == model_q[0], "R5 order", int'(dout), int'(model_q[0]));
        shift_out = 1'b1;
        @(negedge clk);
        while (out_ready) @(negedge clk);
        shift_out = 1'b0;
        void'(model_q.pop_front());
        tick(1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [WIDTH-1:0] saved;
        int pulses;
        void'($urandom(32'd20240611));
        #1 mr = 1'b1;
        tick(3);
        mr = 1'b0;
        tick(1);

        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(out_ready == 1'b0, "R1 out_ready", int'(out_ready), 0);

        // R3 hold in first stage, R4 ripple latency
        din = 4'hA;
        shift_in = 1'b1;
        tick(30);
        chk(in_ready == 1'b0, "R3 busy", int'(in_ready), 0);
        chk(out_ready == 1'b0, "R3 held", int'(out_ready), 0);
        shift_in = 1'b0;
        model_q.push_back(4'hA);
        tick(16);
        chk(out_ready == 1'b0, "R4 early", int'(out_ready), 0);
        tick(1);
        chk(out_ready == 1'b1, "R4 arrive", int'(out_ready), 1);

        // R8 busy while shift_out high, R9 last word kept when empty
        chk(dout == 4'hA, "R5 head", int'(dout), 'hA);
        shift_out = 1'b1;
        tick(4);
        chk(out_ready == 1'b0, "R8 busy", int'(out_ready), 0);
        shift_out = 1'b0;
        void'(model_q.pop_front());
        tick(30);
        chk(out_ready == 1'b0, "R8 stays empty", int'(out_ready), 0);
        chk(dout == 4'hA, "R9 keep", int'(dout), 'hA);

        // R11 output enable
        oe_n = 1'b1;
        tick(1);
        chk(dout_valid == 1'b0, "R11 valid off", int'(dout_valid), 0);
        chk(dout == 4'h0, "R11 zero", int'(dout), 0);
        oe_n = 1'b0;
        tick(1);
        chk(dout_valid == 1'b1, "R11 valid on", int'(dout_valid), 1);
        chk(dout == 4'hA, "R11 data", int'(dout), 'hA);

        // R6 fill to capacity, overflow pulses ignored
        for (int k = 0; k < DEPTH; k++) push_hs(4'(k + 1), 0);
        tick(40);
        chk(in_ready == 1'b0, "R6 full", int'(in_ready), 0);
        for (int k = 0; k < 3; k++) begin
            din = 4'hF;
            shift_in = 1'b1;
            tick(3);
            shift_in = 1'b0;
            tick(3);
        end
        tick(10);
        chk(in_ready == 1'b0, "R6 still full", int'(in_ready), 0);

        // R7 held shift_in while full loads after one read
        din = 4'h7;
        shift_in = 1'b1;
        tick(20);
        chk(in_ready == 1'b0, "R7 waiting", int'(in_ready), 0);
        pop_hs();
        tick(60);
        model_q.push_back(4'h7);
        shift_in = 1'b0;
        tick(40);
        chk(in_ready == 1'b0, "R7 full again", int'(in_ready), 0);
        while (model_q.size() > 0) pop_hs();
        tick(40);
        chk(out_ready == 1'b0, "R8 empty", int'(out_ready), 0);
        chk(dout == 4'h7, "R9 last kept", int'(dout), 7);

        // R10 held shift_out while empty
        shift_out = 1'b1;
        tick(10);
        push_hs(4'h5, 0);
        pulses = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (out_ready) pulses++;
        end
        chk(pulses == 1, "R10 pulse width", pulses, 1);
        chk(dout == 4'h5, "R10 auto word", int'(dout), 5);
        void'(model_q.pop_front());
        push_hs(4'hC, 0);
        tick(40);
        chk(out_ready == 1'b0, "R10 gated", int'(out_ready), 0);
        shift_out = 1'b0;
        tick(5);
        chk(out_ready == 1'b1, "R10 offered", int'(out_ready), 1);
        chk(dout == 4'hC, "R10 next word", int'(dout), 'hC);
        pop_hs();

        // R1 reset mid-operation keeps dout
        for (int k = 0; k < 5; k++) push_hs(4'(k + 8), 0);
        tick(40);
        saved = dout;
        chk(saved == 4'h8, "R5 head before reset", int'(saved), 8);
        do_reset();
        model_q.delete();
        chk(in_ready == 1'b1, "R1 in_ready again", int'(in_ready), 1);
        chk(out_ready == 1'b0, "R1 out_ready again", int'(out_ready), 0);
        chk(dout == saved, "R1 dout kept", int'(dout), int'(saved));
        tick(40);
        chk(out_ready == 1'b0, "R1 emptied", int'(out_ready), 0);

        // R2 shift_in high through reset
        mr = 1'b1;
        din = 4'h3;
        shift_in = 1'b1;
        tick(3);
        mr = 1'b0;
        tick(6);
        chk(in_ready == 1'b0, "R2 loaded", int'(in_ready), 0);
        shift_in = 1'b0;
        model_q.push_back(4'h3);
        tick(25);
        chk(out_ready == 1'b1, "R2 arrive", int'(out_ready), 1);
        chk(dout == 4'h3, "R2 word", int'(dout), 3);
        pop_hs();

        // R12 burst writes without looking at flags
        for (int k = 0; k < 8; k++) begin
            din = 4'(k * 3 + 1);
            shift_in = 1'b1;
            tick(2);
            shift_in = 1'b0;
            tick(2);
            model_q.push_back(4'(k * 3 + 1));
        end
        tick(40);
        chk(out_ready == 1'b1, "R12 burst stored", int'(out_ready), 1);
        while (model_q.size() > 0) pop_hs();

        // R5 constrained random handshakes
        for (int k = 0; k < 200; k++) begin
            bit do_push;
            if (model_q.size() == 0)          do_push = 1'b1;
            else if (model_q.size() == DEPTH) do_push = 1'b0;
            else                              do_push = 1'($urandom_range(0, 1));
            if (do_push) push_hs(4'($urandom_range(0, 15)), int'($urandom_range(0, 2)));
            else         pop_hs();
        end
        while (model_q.size() > 0) pop_hs();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule